// File: doc/BRIEF.md
# SPI Command Front End for a CAN Controller Register Space

This block is the serial slave port of a CAN controller. An SPI master (clock idle low, data captured on the rising edge) opens a frame by pulling chip select low. The first byte of the frame is an opcode, and the block carries out exactly that one command until chip select goes high again. Commands can read or write the 128-byte register space, load a transmit buffer or read a receive buffer through short opcodes that carry their start address, request transmission, return two packed status bytes, or change selected bits of one register.

The register file and the CAN engine sit outside the block. The block reaches the registers through a plain port: an address, write data and a write strobe out, and combinational read data back. It signals the rest of the controller with one-cycle strobes: a soft reset, per-buffer transmit requests, and a release strobe for a receive buffer once the host has read it. The SPI pins are resynchronised to the system clock, so SCK must run several times slower than `clk`.

Top module: `spicmd_decoder`

The control state machine has these states:
- `ST_IDLE`: chip select is high.
- `ST_CMD`: the opcode byte is being received.
- `ST_RADDR` and `ST_WADDR`: the address byte of a read or a write is being received.
- `ST_RDATA`: data is streamed out.
- `ST_WDATA`: data is streamed in.
- `ST_BMADDR`, `ST_BMMASK` and `ST_BMDATA`: the three bytes of a bit modify.
- `ST_STAT` and `ST_RXSTAT`: a status byte is repeated.
- `ST_DRAIN`: all further bytes are ignored.

The transitions are:
- `ST_IDLE` moves to `ST_CMD` when chip select goes low.
- `ST_CMD` moves, once the opcode byte is complete, to the state the opcode selects.
- Each address state moves to its data state.
- `ST_BMADDR` moves to `ST_BMMASK`, then to `ST_BMDATA`, then to `ST_DRAIN`.
- Reset, request-to-send and unknown opcodes move to `ST_DRAIN`.
- Chip select high forces `ST_IDLE` from any state.

## Requirements
- R1: After reset, `spi_miso`, `rf_we`, `soft_rst`, `send_req` and `rx_release` are all 0.
- R2: Opcode 0x03 followed by an address byte (bits 6:0 used) returns the register at that address on the next byte, and the following register on each later byte, for as long as chip select stays low.
- R3: Opcode 0x02 followed by an address byte writes each later data byte to that address, then to the next one, one `rf_we` pulse per byte.
- R4: An address whose bits 3:1 are all ones is presented on `rf_addr` as 0x0E or 0x0F (bits 6:4 cleared), for both reads and writes.
- R5: Opcode 0x05, address, mask, data performs one write of (old & ~mask) | (data & mask) to that address.
- R6: Opcodes 0x90, 0x92, 0x94 and 0x96 start a read at 0x61, 0x66, 0x71 and 0x76 respectively; bit 2 picks the buffer and bit 1 picks the data part.
- R7: When chip select rises after one of the R6 opcodes, `rx_release` pulses for one cycle with bit 0 set for 0x90/0x92 or bit 1 set for 0x94/0x96; no other command causes this pulse.
- R8: Opcodes 0x40 to 0x45 start a write at 0x31, 0x36, 0x41, 0x46, 0x51 and 0x56 respectively; 0x46 and 0x47 write nothing.
- R9: Opcode 0x80 | m pulses `send_req` = m[2:0] for one cycle at the end of the opcode byte.
- R10: Opcode 0xA0 returns on every later byte the status byte with these bits: bit 0 `rx_full[0]`, bit 1 `rx_full[1]`, bits 2/4/6 `tx_req[0..2]`, bits 3/5/7 `tx_empty[0..2]`.
- R11: Opcode 0xB0 returns `rx_status` on every later byte.
- R12: Opcode 0xC0 pulses `soft_rst` for one cycle.
- R13: Only the first byte of a frame is decoded: bytes after a reset, request-to-send, completed bit modify or unknown opcode cause no write and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| rf_addr | output | 7 | Register file address after mirroring |
| rf_wdata | output | 8 | Register file write data |
| rf_we | output | 1 | Register file write strobe |
| rf_rdata | input | 8 | Register file read data (combinational) |
| rx_full | input | 2 | Receive buffer full flags |
| tx_req | input | 3 | Transmit buffer pending-request bits |
| tx_empty | input | 3 | Transmit buffer empty flags |
| rx_status | input | 8 | Receive status byte |
| soft_rst | output | 1 | Soft reset strobe |
| send_req | output | 3 | Per-buffer transmit request strobe |
| rx_release | output | 2 | Receive buffer release strobe |

## Verification
The hardest case is a frame that holds more bytes after a command that should close decoding. The opcode byte has already moved the machine, so bytes that look like valid write opcodes must still be thrown away. To reach this case, the stimulus appends a write opcode, an address and data after request-to-send, reset, bit modify and an unknown opcode. The bench then checks that its register model received no write and saw no strobe. The release strobe also needs care, because it appears only after chip select rises. So every receive-buffer frame is closed fully before the captured pulses are compared.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

    localparam int BYTE_W  = 8;
    localparam int NUM_TXB = 3;
    localparam int NUM_RXB = 2;

    localparam logic [BYTE_W-1:0] OP_RESET  = 8'hC0;
    localparam logic [BYTE_W-1:0] OP_READ   = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h02;
    localparam logic [BYTE_W-1:0] OP_STAT   = 8'hA0;
    localparam logic [BYTE_W-1:0] OP_RXSTAT = 8'hB0;
    localparam logic [BYTE_W-1:0] OP_BITMOD = 8'h05;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_RADDR,
        ST_WADDR,
        ST_RDATA,
        ST_WDATA,
        ST_BMADDR,
        ST_BMMASK,
        ST_BMDATA,
        ST_STAT,
        ST_RXSTAT,
        ST_DRAIN
    } state_e;

    // Interleave the transmit request and empty bits above the two receive-full bits.
    function automatic logic [BYTE_W-1:0] pack_status(
        input logic [NUM_RXB-1:0] full,
        input logic [NUM_TXB-1:0] req,
        input logic [NUM_TXB-1:0] empty
    );
        logic [BYTE_W-1:0] s;
        s[0] = full[0];
        s[1] = full[1];
        for (int i = 0; i < NUM_TXB; i++) begin
            s[2 + 2*i] = req[i];
            s[3 + 2*i] = empty[i];
        end
        return s;
    endfunction

endpackage

// File: rtl/spicmd_sync.sv
module spicmd_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spicmd_shifter.sv
module spicmd_shifter
    import spicmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              load_tick,
    output logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    assign byte_done = active && sck_rise && (cnt == CNT_W'(BYTE_W-1));
    assign rx_byte   = {rx_sh, mosi};
    assign load_tick = active && sck_fall && (cnt == '0);
    assign miso      = tx_sh[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= '0;
        end else if (!active) begin
            cnt   <= '0;
            tx_sh <= '0;
        end else begin
            if (sck_rise) begin
                cnt   <= cnt + 1'b1;
                rx_sh <= {rx_sh[BYTE_W-3:0], mosi};
            end
            if (sck_fall) begin
                if (cnt == '0) tx_sh <= load_byte;
                else           tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spicmd_decoder.sv
module spicmd_decoder
    import spicmd_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sck,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    output logic               spi_miso,
    output logic [ADDR_W-1:0]  rf_addr,
    output logic [BYTE_W-1:0]  rf_wdata,
    output logic               rf_we,
    input  logic [BYTE_W-1:0]  rf_rdata,
    input  logic [NUM_RXB-1:0] rx_full,
    input  logic [NUM_TXB-1:0] tx_req,
    input  logic [NUM_TXB-1:0] tx_empty,
    input  logic [BYTE_W-1:0]  rx_status,
    output logic               soft_rst,
    output logic [NUM_TXB-1:0] send_req,
    output logic [NUM_RXB-1:0] rx_release
);
    localparam int PAGE_W = 4;

    logic cs_s, sck_s, mosi_s, sck_d, active, active_d;
    logic sck_rise, sck_fall, byte_done, load_tick;
    logic [BYTE_W-1:0] rx_byte, load_byte, mask_q;
    logic [ADDR_W-1:0] addr_q, cmd_addr;
    logic is_rxbuf, is_txload, is_rts, rel_vld;
    logic rel_buf;
    state_e state, nxt;

    spicmd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_cs_n, spi_sck, spi_mosi}),
        .q({cs_s, sck_s, mosi_s})
    );

    assign active   = !cs_s;
    assign sck_rise = sck_s && !sck_d;
    assign sck_fall = !sck_s && sck_d;

    spicmd_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .active(active),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi(mosi_s),
        .load_byte(load_byte), .byte_done(byte_done), .rx_byte(rx_byte),
        .load_tick(load_tick), .miso(spi_miso)
    );

    // Opcode classes that carry an address or a buffer mask.
    assign is_rxbuf  = (rx_byte[7:3] == 5'b10010) && !rx_byte[0];
    assign is_txload = (rx_byte[7:3] == 5'b01000) && (rx_byte[2:1] != 2'b11);
    assign is_rts    = (rx_byte[7:3] == 5'b10000);

    always_comb begin
        if (is_rxbuf)
            cmd_addr = ADDR_W'({2'b11, rx_byte[2], (rx_byte[1] ? 4'h6 : 4'h1)});
        else
            cmd_addr = ADDR_W'({3'(rx_byte[2:1]) + 3'd3, (rx_byte[0] ? 4'h6 : 4'h1)});
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        if (!active) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   nxt = ST_CMD;
                ST_CMD: if (byte_done) begin
                    if      (rx_byte == OP_READ)   nxt = ST_RADDR;
                    else if (rx_byte == OP_WRITE)  nxt = ST_WADDR;
                    else if (rx_byte == OP_STAT)   nxt = ST_STAT;
                    else if (rx_byte == OP_RXSTAT) nxt = ST_RXSTAT;
                    else if (rx_byte == OP_BITMOD) nxt = ST_BMADDR;
                    else if (is_rxbuf)             nxt = ST_RDATA;
                    else if (is_txload)            nxt = ST_WDATA;
                    else                           nxt = ST_DRAIN;
                end
                ST_RADDR:  if (byte_done) nxt = ST_RDATA;
                ST_WADDR:  if (byte_done) nxt = ST_WDATA;
                ST_BMADDR: if (byte_done) nxt = ST_BMMASK;
                ST_BMMASK: if (byte_done) nxt = ST_BMDATA;
                ST_BMDATA: if (byte_done) nxt = ST_DRAIN;
                ST_RDATA, ST_WDATA, ST_STAT, ST_RXSTAT, ST_DRAIN: nxt = state;
                default:   nxt = ST_DRAIN;
            endcase
        end
    end

    // Address pointer, mask, strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d      <= 1'b0;
            active_d   <= 1'b0;
            addr_q     <= '0;
            mask_q     <= '0;
            rel_vld    <= 1'b0;
            rel_buf    <= 1'b0;
            soft_rst   <= 1'b0;
            send_req   <= '0;
            rx_release <= '0;
        end else begin
            sck_d      <= sck_s;
            active_d   <= active;
            soft_rst   <= 1'b0;
            send_req   <= '0;
            rx_release <= '0;
            if (active_d && !active && rel_vld)
                rx_release <= NUM_RXB'(1) << rel_buf;
            if (!active) rel_vld <= 1'b0;
            if (byte_done) begin
                unique case (state)
                    ST_CMD: begin
                        addr_q   <= cmd_addr;
                        rel_vld  <= is_rxbuf;
                        rel_buf  <= rx_byte[2];
                        soft_rst <= (rx_byte == OP_RESET);
                        send_req <= is_rts ? rx_byte[NUM_TXB-1:0] : '0;
                    end
                    ST_RADDR, ST_WADDR, ST_BMADDR: addr_q <= rx_byte[ADDR_W-1:0];
                    ST_BMMASK: mask_q <= rx_byte;
                    ST_WDATA:  addr_q <= addr_q + 1'b1;
                    default: ;
                endcase
            end
            if (load_tick && state == ST_RDATA) addr_q <= addr_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        rf_addr = (addr_q[PAGE_W-1:1] == {(PAGE_W-1){1'b1}})
                ? {{(ADDR_W-PAGE_W){1'b0}}, addr_q[PAGE_W-1:0]} : addr_q;
        rf_we    = byte_done && (state == ST_WDATA || state == ST_BMDATA);
        rf_wdata = (state == ST_BMDATA) ? ((rf_rdata & ~mask_q) | (rx_byte & mask_q)) : rx_byte;
        unique case (state)
            ST_RDATA:  load_byte = rf_rdata;
            ST_STAT:   load_byte = pack_status(rx_full, tx_req, tx_empty);
            ST_RXSTAT: load_byte = rx_status;
            default:   load_byte = '0;
        endcase
    end
endmodule

// File: rtl/spicmd_decoder_chk.sv
module spicmd_decoder_chk
    import spicmd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rf_we,
    input logic               soft_rst,
    input logic [NUM_TXB-1:0] send_req,
    input logic [NUM_RXB-1:0] rx_release
);
    // R3
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);
    // R9
    send_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send_req != '0) |=> (send_req == '0));
    // R12
    srst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);
    // R7
    release_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_release));
    // R7
    release_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_release != '0) |=> (rx_release == '0));
endmodule

bind spicmd_decoder spicmd_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .soft_rst(soft_rst),
    .send_req(send_req), .rx_release(rx_release)
);

// File: tb/tb_spicmd_decoder.sv
module tb_spicmd_decoder;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_miso;
    logic [6:0] rf_addr;
    logic [7:0] rf_wdata, rf_rdata;
    logic rf_we, soft_rst;
    logic [1:0] rx_full = 2'b00, rx_release;
    logic [2:0] tx_req = 3'b000, tx_empty = 3'b000, send_req;
    logic [7:0] rx_status = 8'h00;

    logic [7:0] mem [128];
    logic       mon_clr = 1'b0, pre_en = 1'b0;
    logic [6:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    int wr_cnt, srst_cnt, send_cnt;
    logic [2:0] send_seen;
    logic [1:0] rel_seen;
    int nchk = 0, nfail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spicmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_rdata(rf_rdata),
        .rx_full(rx_full), .tx_req(tx_req), .tx_empty(tx_empty),
        .rx_status(rx_status), .soft_rst(soft_rst), .send_req(send_req),
        .rx_release(rx_release)
    );

    assign rf_rdata = mem[rf_addr];

    // Register file model and strobe monitors
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else if (rf_we) begin
            mem[rf_addr] <= rf_wdata;
        end else if (pre_en) begin
            mem[pre_addr] <= pre_data;
        end
        if (mon_clr || !rst_n) begin
            wr_cnt <= 0; srst_cnt <= 0; send_cnt <= 0;
            send_seen <= '0; rel_seen <= '0;
        end else begin
            if (rf_we) wr_cnt <= wr_cnt + 1;
            if (soft_rst) srst_cnt <= srst_cnt + 1;
            if (send_req != '0) send_cnt <= send_cnt + 1;
            send_seen <= send_seen | send_req;
            rel_seen  <= rel_seen | rx_release;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk); pre_addr = a; pre_data = d; pre_en = 1'b1;
        @(negedge clk); pre_en = 1'b0;
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic open_frame();
        clear_mon();
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic close_frame();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2*HALF + 4) @(negedge clk);
    endtask

    // {opcode, expected start address or FF for none}
    localparam logic [15:0] VEC [12] = '{
        16'h9061, 16'h9266, 16'h9471, 16'h9676,
        16'h4031, 16'h4136, 16'h4241, 16'h4346, 16'h4451, 16'h4556,
        16'h46FF, 16'h47FF
    };

    initial begin
        #2_000_000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r0, r1, r2, r3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 miso", spi_miso, 0);
        chk("R1 we", rf_we, 0);
        chk("R1 strobes", {soft_rst, send_req, rx_release}, 0);

        // Shortcut address table: R6 R7 R8
        for (int v = 0; v < 12; v++) begin
            logic [7:0] op, ea;
            op = VEC[v][15:8]; ea = VEC[v][7:0];
            open_frame();
            xfer(op, r0);
            if (op[7]) begin
                xfer(8'h00, r0); xfer(8'h00, r1);
                close_frame();
                chk("R6 first", r0, ea ^ 8'h5A);
                chk("R6 second", r1, (ea + 8'd1) ^ 8'h5A);
                chk("R7 release", rel_seen, op[2] ? 2 : 1);
            end else begin
                xfer(8'hC0 + 8'(v), r0); xfer(8'h30 + 8'(v), r1);
                close_frame();
                if (ea == 8'hFF) begin
                    chk("R8 reserved no write", wr_cnt, 0);
                end else begin
                    chk("R8 first", mem[ea[6:0]], 8'hC0 + 8'(v));
                    chk("R8 second", mem[ea[6:0] + 7'd1], 8'h30 + 8'(v));
                    chk("R7 no release", rel_seen, 0);
                end
            end
        end

        // R2 burst read with increment
        open_frame();
        xfer(8'h03, r0); xfer(8'h0C, r0);
        xfer(8'h00, r0); xfer(8'h00, r1); xfer(8'h00, r2); xfer(8'h00, r3);
        close_frame();
        chk("R2 b0", r0, 8'h0C ^ 8'h5A);
        chk("R2 b1", r1, 8'h0D ^ 8'h5A);
        chk("R2 b2", r2, 8'h0E ^ 8'h5A);
        chk("R2 b3", r3, 8'h0F ^ 8'h5A);
        chk("R7 plain read no release", rel_seen, 0);

        // R4 mirror on read and write
        open_frame();
        xfer(8'h03, r0); xfer(8'h3E, r0); xfer(8'h00, r0); xfer(8'h00, r1);
        close_frame();
        chk("R4 read E", r0, 8'h0E ^ 8'h5A);
        chk("R4 read F", r1, 8'h0F ^ 8'h5A);
        open_frame();
        xfer(8'h02, r0); xfer(8'h5F, r0); xfer(8'h77, r0);
        close_frame();
        chk("R4 write F", mem[7'h0F], 8'h77);
        chk("R4 page untouched", mem[7'h5F], 8'h5F ^ 8'h5A);

        // R3 sequential write
        open_frame();
        xfer(8'h02, r0); xfer(8'h20, r0);
        xfer(8'h10, r0); xfer(8'h20, r0); xfer(8'h30, r0);
        close_frame();
        chk("R3 count", wr_cnt, 3);
        chk("R3 a20", mem[7'h20], 8'h10);
        chk("R3 a21", mem[7'h21], 8'h20);
        chk("R3 a22", mem[7'h22], 8'h30);

        // R5 bit modify, R13 trailing byte ignored
        preload(7'h28, 8'hA5);
        open_frame();
        xfer(8'h05, r0); xfer(8'h28, r0); xfer(8'h0F, r0); xfer(8'h3C, r0);
        xfer(8'hFF, r0);
        close_frame();
        chk("R5 value", mem[7'h28], 8'hAC);
        chk("R13 single write", wr_cnt, 1);

        // R10 status packing, repeated
        rx_full = 2'b01; tx_req = 3'b100; tx_empty = 3'b011;
        open_frame();
        xfer(8'hA0, r0); xfer(8'h00, r0); xfer(8'h00, r1);
        close_frame();
        chk("R10 byte1", r0, 8'h69);
        chk("R10 byte2", r1, 8'h69);

        // R11 receive status
        rx_status = 8'h5C;
        open_frame();
        xfer(8'hB0, r0); xfer(8'h00, r0); xfer(8'h00, r1);
        close_frame();
        chk("R11 byte1", r0, 8'h5C);
        chk("R11 byte2", r1, 8'h5C);

        // R9 request to send, R13 trailing write ignored
        open_frame();
        xfer(8'h85, r0); xfer(8'h02, r0); xfer(8'h20, r0); xfer(8'hEE, r0);
        close_frame();
        chk("R9 mask", send_seen, 3'b101);
        chk("R9 once", send_cnt, 1);
        chk("R13 after rts", wr_cnt, 0);

        // R12 soft reset
        open_frame();
        xfer(8'hC0, r0); xfer(8'h02, r0); xfer(8'h20, r0); xfer(8'hEE, r0);
        close_frame();
        chk("R12 pulse", srst_cnt, 1);
        chk("R13 after reset", wr_cnt, 0);

        // R13 unknown opcode
        open_frame();
        xfer(8'h13, r0); xfer(8'h02, r0); xfer(8'h20, r0); xfer(8'h55, r0);
        close_frame();
        chk("R13 unknown writes", wr_cnt, 0);
        chk("R13 unknown strobes", srst_cnt + send_cnt + int'(rel_seen), 0);
        chk("R13 a20 kept", mem[7'h20], 8'h10);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule